// File: doc/BRIEF.md
# Serial link error status register

This block keeps the error status of one serial storage link port in a single 32-bit register. Error sources in the physical, link and transport layers each send a one-cycle pulse. Each pulse sets its own bit, and that bit stays set until software writes a 1 to it. The upper half of the register holds diagnostic flags. The lower half holds flags that host software acts on.

The block also watches the PHY-ready level and flags any change of it, in either direction. It copies two of the flags to interrupt-status outputs: the device-presence flag and the PHY-ready change flag. It holds a stop-transfer output high while any of the four serious host-response errors is present. The port is read continuously through `rd_data`, and a write takes effect on the clock edge at which `wr_en` is high.

Top module: `link_err_status`

## Requirements
- R1: After reset, `rd_data` is zero and all three status outputs and `stop_xfer` are low.
- R2: Every implemented bit is sticky. A write with `wr_en` high clears exactly the bits where `wr_data` is 1. Bits where `wr_data` is 0 keep their value.
- R3: Bits 31:27, 23, 20 (disparity), 15:12 and 7:0 always read 0. Writes to them and events never change them. The implemented mask is 32'h076F_0F00.
- R4: A one-cycle pulse sets its diagnostic bit on the next clock edge. The mapping is: `ev_link_init` to bit 26, `ev_bad_fis_type` to bit 25, `ev_xport_state` to bit 24, `ev_nak_hshake` to bit 22, `ev_link_crc` to bit 21, `ev_decode` to bit 19, `ev_wake` to bit 18 and `ev_phy_fault` to bit 17.
- R5: A one-cycle pulse sets its host-response bit on the next clock edge. The mapping is: `ev_mem_abort` to bit 11, `ev_protocol` to bit 10, `ev_aux_hi` to bit 9 and `ev_aux_lo` to bit 8.
- R6: Bit 16 sets on the clock edge at which `phy_ready` is first sampled with a level different from the previous sample. This applies to both directions. No change is flagged at the first clock edge after reset.
- R7: If an event and a write-1 clear hit the same bit at the same edge, the bit ends up set.
- R8: `conn_chg_sts` equals bit 26 and `rdy_chg_sts` equals bit 16. `rdy_chg_irq` is high exactly when bit 16 is set and `rdy_chg_en` is high.
- R9: `stop_xfer` is high exactly while any of bits 11:8 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the clear operation |
| wr_data | input | 32 | Write-1-to-clear mask |
| rd_data | output | 32 | Current register value |
| ev_link_init | input | 1 | Link-initialisation signal received from the device |
| ev_bad_fis_type | input | 1 | Frame with good CRC but an unknown type |
| ev_xport_state | input | 1 | Transport-layer state transition error |
| ev_nak_hshake | input | 1 | Negative handshake on a transmitted frame |
| ev_link_crc | input | 1 | Link-layer CRC error |
| ev_decode | input | 1 | 10b-to-8b decode error |
| ev_wake | input | 1 | Wake signal detected |
| ev_phy_fault | input | 1 | PHY internal error |
| phy_ready | input | 1 | PHY-ready level |
| ev_mem_abort | input | 1 | System-memory access ended in a master or target abort |
| ev_protocol | input | 1 | Protocol violation |
| ev_aux_hi | input | 1 | Generic serious error, bit 9 |
| ev_aux_lo | input | 1 | Generic serious error, bit 8 |
| rdy_chg_en | input | 1 | Enable for the PHY-ready change interrupt |
| conn_chg_sts | output | 1 | Presence-change status |
| rdy_chg_sts | output | 1 | PHY-ready change status |
| rdy_chg_irq | output | 1 | PHY-ready change interrupt |
| stop_xfer | output | 1 | Stop the current transfer |

## Verification
The bench pulses every event source on its own and checks that the whole 32-bit word has exactly the expected bit set. A wrong mapping would set a neighbouring bit, and a missing mask would leak a set bit into a reserved position. It then fills every flag and clears single bits one at a time, including every reserved position. A clear that reached too far would drop other flags, and a reserved bit that stored data would read back as 1.

The bench also drives an event into a bit in the same cycle that software clears it. A design that let the clear win would lose that event. Finally, it steps `phy_ready` through both edges and through a level held across reset. A design that detected only one edge, or that flagged a change on the first cycle after reset, would show up there.

// File: rtl/link_err_status.sv
module link_err_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        ev_link_init,
  input  logic        ev_bad_fis_type,
  input  logic        ev_xport_state,
  input  logic        ev_nak_hshake,
  input  logic        ev_link_crc,
  input  logic        ev_decode,
  input  logic        ev_wake,
  input  logic        ev_phy_fault,
  input  logic        phy_ready,
  input  logic        ev_mem_abort,
  input  logic        ev_protocol,
  input  logic        ev_aux_hi,
  input  logic        ev_aux_lo,
  input  logic        rdy_chg_en,
  output logic        conn_chg_sts,
  output logic        rdy_chg_sts,
  output logic        rdy_chg_irq,
  output logic        stop_xfer
);

  localparam logic [31:0] IMPL_MASK = 32'h076F_0F00;

  logic [31:0] err_q;
  logic [31:0] set_vec;
  logic [31:0] clr_vec;
  logic        rdy_q;
  logic        rdy_seen_q;
  logic        rdy_toggle;

  assign rdy_toggle = rdy_seen_q && (phy_ready != rdy_q);

  always_comb begin
    set_vec     = '0;
    set_vec[26] = ev_link_init;
    set_vec[25] = ev_bad_fis_type;
    set_vec[24] = ev_xport_state;
    set_vec[22] = ev_nak_hshake;
    set_vec[21] = ev_link_crc;
    set_vec[19] = ev_decode;
    set_vec[18] = ev_wake;
    set_vec[17] = ev_phy_fault;
    set_vec[16] = rdy_toggle;
    set_vec[11] = ev_mem_abort;
    set_vec[10] = ev_protocol;
    set_vec[9]  = ev_aux_hi;
    set_vec[8]  = ev_aux_lo;
  end

  assign clr_vec = wr_en ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q      <= '0;
      rdy_q      <= 1'b0;
      rdy_seen_q <= 1'b0;
    end else begin
      err_q      <= ((err_q & ~clr_vec) | set_vec) & IMPL_MASK;
      rdy_q      <= phy_ready;
      rdy_seen_q <= 1'b1;
    end
  end

  assign rd_data      = err_q;
  assign conn_chg_sts = err_q[26];
  assign rdy_chg_sts  = err_q[16];
  assign rdy_chg_irq  = err_q[16] & rdy_chg_en;
  assign stop_xfer    = |err_q[11:8];

endmodule

module link_err_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        ev_link_crc,
  input logic        ev_mem_abort,
  input logic        rdy_chg_en,
  input logic        conn_chg_sts,
  input logic        rdy_chg_sts,
  input logic        rdy_chg_irq,
  input logic        stop_xfer
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~32'h076F_0F00) == 32'h0); // R3

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((rd_data & $past(rd_data)) == $past(rd_data))); // R2

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_data & rd_data) == 32'h0)) |=> ((rd_data & $past(rd_data)) == $past(rd_data))); // R2

  AST_CRC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_link_crc |=> rd_data[21]); // R4

  AST_ABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mem_abort |=> (rd_data[11] && stop_xfer)); // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_link_crc && wr_en && wr_data[21]) |=> rd_data[21]); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_chg_irq |-> (rdy_chg_en && rdy_chg_sts)); // R8

  AST_MIRRORS: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_chg_sts == rd_data[26]) && (rdy_chg_sts == rd_data[16])); // R8

  AST_STOP_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[11:8] == 4'h0) |-> !stop_xfer); // R9

endmodule

bind link_err_status link_err_status_chk chk_i (.*);

// File: tb/link_err_status_tb.sv
module link_err_status_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [11:0] ev = '0;
  logic        phy_ready = 1'b1;
  logic        rdy_chg_en = 1'b0;
  logic        conn_chg_sts, rdy_chg_sts, rdy_chg_irq, stop_xfer;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [31:0] MASK = 32'h076F_0F00;

  always #5 clk = ~clk;

  link_err_status dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_link_init(ev[0]), .ev_bad_fis_type(ev[1]), .ev_xport_state(ev[2]),
    .ev_nak_hshake(ev[3]), .ev_link_crc(ev[4]), .ev_decode(ev[5]),
    .ev_wake(ev[6]), .ev_phy_fault(ev[7]), .phy_ready(phy_ready),
    .ev_mem_abort(ev[8]), .ev_protocol(ev[9]), .ev_aux_hi(ev[10]), .ev_aux_lo(ev[11]),
    .rdy_chg_en(rdy_chg_en), .conn_chg_sts(conn_chg_sts), .rdy_chg_sts(rdy_chg_sts),
    .rdy_chg_irq(rdy_chg_irq), .stop_xfer(stop_xfer)
  );

  function automatic int bit_of(input int i);
    case (i)
      0: return 26;  1: return 25;  2: return 24;  3: return 22;
      4: return 21;  5: return 19;  6: return 18;  7: return 17;
      8: return 11;  9: return 10;  10: return 9;  default: return 8;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic clear_all();
    wr_en = 1'b1; wr_data = '1;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] exp;
    #12;
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 outputs", {28'h0, conn_chg_sts, rdy_chg_sts, rdy_chg_irq, stop_xfer}, 32'h0);
    rst_n = 1'b1;
    tick();
    // R6: phy_ready already 1 at the first edge; no change flagged
    chg("R6 first edge");
    tick();
    chk("R6 steady", rd_data, 32'h0);

    // R4 R5 R9 R8: each source alone
    for (int i = 0; i < 12; i++) begin
      ev[i] = 1'b1;
      tick();
      ev = '0;
      exp = 32'h1 << bit_of(i);
      chk(i < 8 ? "R4 map" : "R5 map", rd_data, exp);
      chk("R9 stop", {31'h0, stop_xfer}, {31'h0, |exp[11:8]});
      chk("R8 conn", {31'h0, conn_chg_sts}, {31'h0, exp[26]});
      tick();
      chk("R2 sticky", rd_data, exp);
      clear_all();
      chk("R2 cleared", rd_data, 32'h0);
    end

    // R6: both edges, R8 interrupt gating
    phy_ready = 1'b0;
    tick();
    chk("R6 fall", rd_data, 32'h0001_0000);
    chk("R8 rdy sts", {31'h0, rdy_chg_sts}, 32'h1);
    chk("R8 irq off", {31'h0, rdy_chg_irq}, 32'h0);
    rdy_chg_en = 1'b1;
    #1;
    chk("R8 irq on", {31'h0, rdy_chg_irq}, 32'h1);
    clear_all();
    chk("R6 cleared", rd_data, 32'h0);
    chk("R8 irq cleared", {31'h0, rdy_chg_irq}, 32'h0);
    phy_ready = 1'b1;
    tick();
    chk("R6 rise", rd_data, 32'h0001_0000);
    clear_all();

    // R2 R3: fill everything, then clear one position at a time
    ev = '1; phy_ready = 1'b0;
    tick();
    ev = '0;
    chk("R3 fill", rd_data, MASK);
    wr_en = 1'b1; wr_data = '0;
    tick();
    chk("R2 zero write", rd_data, MASK);
    exp = MASK;
    for (int k = 0; k < 32; k++) begin
      wr_data = 32'h1 << k;
      tick();
      exp = exp & ~(32'h1 << k);
      chk("R2 R3 single clear", rd_data, exp);
    end
    wr_en = 1'b0; wr_data = '0;

    // R7: event and clear of same bit in same cycle
    for (int i = 0; i < 12; i++) begin
      ev[i] = 1'b1; wr_en = 1'b1; wr_data = 32'h1 << bit_of(i);
      tick();
      ev = '0; wr_en = 1'b0; wr_data = '0;
      chk("R7 set wins", rd_data, 32'h1 << bit_of(i));
      clear_all();
    end
    // R7: phy toggle against clear of bit 16
    phy_ready = 1'b1; wr_en = 1'b1; wr_data = 32'h0001_0000;
    tick();
    wr_en = 1'b0; wr_data = '0;
    chk("R7 rdy set wins", rd_data, 32'h0001_0000);
    clear_all();

    // R3: writing ones to reserved leaves zeros; nothing set
    wr_en = 1'b1; wr_data = ~MASK;
    tick();
    wr_en = 1'b0;
    chk("R3 rsvd write", rd_data, 32'h0);

    finish_up();
  end

  task automatic chg(input string req);
    chk(req, rd_data, 32'h0);
  endtask

endmodule